// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a stream of 32.768 kHz oscillator ticks into one-second increment pulses for a time-of-day counter. A crystal that runs fast or slow is corrected digitally: on three seconds out of every sixty (those whose BCD seconds value reads 00, 20 or 40) the number of oscillator ticks that make up the second is stretched or shortened by an even amount. Every other second keeps the nominal length.

The 7-bit trim code uses bit 6 as a direction flag and bits 5..0 as a magnitude field. With bit 6 clear the second grows by 2 × (field − 1) ticks; with bit 6 set it shrinks by 2 × (inverted field + 1) ticks. Codes whose bits 5..1 are all zero leave the length alone. One two-tick step is about 3.05 ppm over a twenty-second span. The seconds value of the running second and the trim code are both captured on the first tick of each second, so a change in mid-second acts from the next one. The untrimmed tick stream is passed straight through to an output of its own.

Top module: `secs_trim_prescaler`

## Requirements
- R1: A second whose captured seconds value is not 8'h00, 8'h20 or 8'h40 lasts exactly NOMINAL oscillator ticks (default 32768), whatever the trim code.
- R2: When the captured seconds value is 8'h00, 8'h20 or 8'h40 and trim bit 6 is 0 (with bits 5..1 not all zero), the second lasts NOMINAL + 2 × (trim[5:0] − 1) ticks.
- R3: When the captured seconds value is 8'h00, 8'h20 or 8'h40 and trim bit 6 is 1 (with bits 5..1 not all zero), the second lasts NOMINAL − 2 × ((~trim[5:0]) + 1) ticks; code 7'b1111110 gives NOMINAL − 4.
- R4: A trim code whose bits 5..1 are all zero (7'h00, 7'h01, 7'h40, 7'h41) gives a second of NOMINAL ticks even on seconds 00, 20 and 40.
- R5: The trim code and seconds value are sampled on the first tick of each second; changing either one during a second does not alter that second's length.
- R6: The increment output is a registered pulse one clock wide, asserted in the clock cycle after the tick that ends the second.
- R7: Clocks without an oscillator tick neither advance the second nor produce a pulse.
- R8: The raw tick output follows the oscillator tick input in every cycle, unaffected by trim.
- R9: During reset the increment output is low; the first second after reset starts on the first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-clock enable per oscillator cycle |
| trim_code | input | 7 | Trim setting: bit 6 direction, bits 5..0 magnitude |
| sec_bcd | input | 8 | Current BCD seconds value from the time counter |
| sec_inc | output | 1 | One-clock pulse that advances the seconds count |
| raw_tick_out | output | 1 | Untrimmed oscillator tick stream |

## Verification
A wrong length latch or a miscounting tick counter shows up as a second that is too long or too short, visible at the very next increment pulse, at most one second after the fault. The bench therefore measures every second as a tick count between pulses and compares it with a length computed from the trim formulas, covering the extreme codes on both sides, the four no-adjust codes and seconds values just outside the three trim slots. A mid-second trim change and a pause in the tick stream expose a latch that samples at the wrong time or a counter that moves without ticks, both within the second in which they occur.

// File: rtl/sprt_pkg.sv
package sprt_pkg;

  localparam int TRIM_W    = 7;
  localparam int SLOT_CNT  = 3;
  localparam int MAX_SHIFT = 124;

  // Signed tick offset for a trimmed second.
  function automatic int trim_offset(input logic [TRIM_W-1:0] code);
    logic [5:0] inv;
    int         mag;
    if (code[5:1] == 5'd0) begin
      return 0;
    end
    if (!code[6]) begin
      mag = int'(code[5:0]) - 1;
      return 2 * mag;
    end
    inv = ~code[5:0];
    mag = int'(inv) + 1;
    return -2 * mag;
  endfunction

  // BCD seconds value of trim slot i: 00, 20, 40.
  function automatic logic [7:0] slot_bcd(input int i);
    return 8'(i * 32);
  endfunction

endpackage

// File: rtl/sprt_window.sv
module sprt_window (
  input  logic [7:0] sec_bcd,
  output logic       trim_slot
);
  import sprt_pkg::*;

  logic [SLOT_CNT-1:0] slot_hit;

  for (genvar gi = 0; gi < SLOT_CNT; gi++) begin : g_slot
    assign slot_hit[gi] = (sec_bcd == slot_bcd(gi));
  end

  assign trim_slot = |slot_hit;
endmodule

// File: rtl/sprt_length.sv
module sprt_length #(
  parameter int NOMINAL = 32768,
  parameter int CNT_W   = 16
) (
  input  logic [6:0]       trim_code,
  input  logic             trim_slot,
  output logic [CNT_W-1:0] next_len
);
  import sprt_pkg::*;

  logic signed [31:0] len_full;

  always_comb begin
    if (trim_slot) begin
      len_full = NOMINAL + trim_offset(trim_code);
    end else begin
      len_full = NOMINAL;
    end
    next_len = CNT_W'(len_full);
  end
endmodule

// File: rtl/sprt_counter.sv
module sprt_counter #(
  parameter int NOMINAL = 32768,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] next_len,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] len_q,
  output logic             start_evt,
  output logic             term_hit
);
  localparam logic [CNT_W-1:0] NOM_LEN = CNT_W'(NOMINAL);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  assign start_evt = tick && (cnt_q == '0);
  assign term_hit  = tick && (cnt_q == len_q - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= NOM_LEN;
    end else begin
      if (tick) begin
        if (term_hit) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end
      if (start_evt) begin
        len_q <= next_len;
      end
    end
  end
endmodule

// File: rtl/secs_trim_prescaler.sv
module secs_trim_prescaler #(
  parameter int NOMINAL = 32768,
  parameter int CNT_W   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [6:0] trim_code,
  input  logic [7:0] sec_bcd,
  output logic       sec_inc,
  output logic       raw_tick_out
);
  logic             trim_slot;
  logic [CNT_W-1:0] next_len;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             start_evt;
  logic             term_hit;

  sprt_window u_window (
    .sec_bcd   (sec_bcd),
    .trim_slot (trim_slot)
  );

  sprt_length #(.NOMINAL(NOMINAL), .CNT_W(CNT_W)) u_length (
    .trim_code (trim_code),
    .trim_slot (trim_slot),
    .next_len  (next_len)
  );

  sprt_counter #(.NOMINAL(NOMINAL), .CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (osc_tick),
    .next_len  (next_len),
    .cnt_q     (cnt_q),
    .len_q     (len_q),
    .start_evt (start_evt),
    .term_hit  (term_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_inc <= 1'b0;
    end else begin
      sec_inc <= term_hit;
    end
  end

  assign raw_tick_out = osc_tick;
endmodule

// File: rtl/sprt_checks.sv
module sprt_checks #(
  parameter int NOMINAL = 32768,
  parameter int CNT_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_tick,
  input logic [6:0]       trim_code,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] len_q,
  input logic             start_evt,
  input logic             term_hit,
  input logic             sec_inc
);
  localparam logic [CNT_W-1:0] NOM_LEN = CNT_W'(NOMINAL);

  a_r6_one_clock_wide: assert property (@(posedge clk) disable iff (!rst_n)
    sec_inc |=> !sec_inc);

  a_r6_follows_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    sec_inc |-> $past(term_hit));

  a_r7_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(cnt_q));

  a_r5_length_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(len_q));

  a_r4_no_adjust_code: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && cnt_q == '0 && trim_code[5:1] == 5'd0) |=> (len_q == NOM_LEN));

  a_r1_count_below_length: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q);
endmodule

bind secs_trim_prescaler sprt_checks #(.NOMINAL(NOMINAL), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_tick  (osc_tick),
  .trim_code (trim_code),
  .cnt_q     (cnt_q),
  .len_q     (len_q),
  .start_evt (start_evt),
  .term_hit  (term_hit),
  .sec_inc   (sec_inc)
);

// File: tb/sim_secs_trim_prescaler.sv
module sim_secs_trim_prescaler;
  localparam int N  = 512;
  localparam int CW = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       tick_en = 1'b0;
  logic [6:0] trim_code = 7'd0;
  logic [7:0] sec_bcd = 8'h05;
  logic       sec_inc;
  logic       raw_tick_out;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_total = 0;
  int tick_base  = 0;
  int cycles     = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  secs_trim_prescaler #(.NOMINAL(N), .CNT_W(CW)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_tick     (osc_tick),
    .trim_code    (trim_code),
    .sec_bcd      (sec_bcd),
    .sec_inc      (sec_inc),
    .raw_tick_out (raw_tick_out)
  );

  always #4 clk = ~clk;

  // tick stream: one tick every second clock while enabled
  initial begin
    forever begin
      @(negedge clk);
      osc_tick = tick_en & ~osc_tick;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && osc_tick) tick_total <= tick_total + 1;
  end

  function automatic int ref_len(input logic [7:0] s, input logic [6:0] t);
    bit slot;
    slot = (s == 8'h00) || (s == 8'h20) || (s == 8'h40);
    if (!slot || t[5:1] == 5'd0) return N;
    if (t[6] == 1'b0) return N + 2 * (int'(t[5:0]) - 1);
    return N - 2 * (64 - int'(t[5:0]));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: measure each second and compare against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && sec_inc) begin
        if (exp_q.size() == 0) begin
          n_checks++;
          n_fail++;
          $display("FAIL R6: actual unexpected pulse expected none");
        end else begin
          check(tag_q.pop_front(), tick_total - tick_base, exp_q.pop_front());
        end
        tick_base = tick_total;
        check("R8", int'(raw_tick_out), int'(osc_tick));
      end
    end
  end

  task automatic wait_pulse(input string req);
    int k = 0;
    while (!sec_inc && k < 4000) begin
      @(negedge clk);
      k++;
    end
    if (!sec_inc) check(req, 0, 1);
    @(negedge clk);
    check("R6", int'(sec_inc), 0);
  endtask

  task automatic run_second(input string req, input logic [7:0] s, input logic [6:0] t);
    sec_bcd   = s;
    trim_code = t;
    exp_q.push_back(ref_len(s, t));
    tag_q.push_back(req);
    tick_en = 1'b1;
    @(negedge clk);
    wait_pulse(req);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R9", int'(sec_inc), 0);
    check("R8", int'(raw_tick_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_second("R1", 8'h05, 7'b0101001);
    run_second("R2", 8'h00, 7'b0101001);
    run_second("R4", 8'h20, 7'b0000001);
    run_second("R3", 8'h40, 7'b1111110);
    run_second("R4", 8'h40, 7'b1000000);
    run_second("R4", 8'h00, 7'b1000001);
    run_second("R4", 8'h20, 7'b0000000);
    run_second("R2", 8'h20, 7'b0111111);
    run_second("R3", 8'h00, 7'b1000010);
    run_second("R3", 8'h40, 7'b1111111);
    run_second("R1", 8'h10, 7'b1000010);
    run_second("R1", 8'h59, 7'b0111111);
    run_second("R1", 8'h21, 7'b0000101);

    // R5: change trim and seconds part-way through a second
    sec_bcd   = 8'h00;
    trim_code = 7'b0000101;
    exp_q.push_back(ref_len(8'h00, 7'b0000101));
    tag_q.push_back("R5");
    repeat (200) @(negedge clk);
    trim_code = 7'b1111110;
    sec_bcd   = 8'h33;
    wait_pulse("R5");
    run_second("R5", 8'h00, 7'b1111110);

    // R7: pause the tick stream in mid-second
    sec_bcd   = 8'h20;
    trim_code = 7'b0000011;
    exp_q.push_back(ref_len(8'h20, 7'b0000011));
    tag_q.push_back("R7");
    repeat (300) @(negedge clk);
    tick_en = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (sec_inc) seen++;
      end
      check("R7", seen, 0);
    end
    tick_en = 1'b1;
    wait_pulse("R7");

    check("R6", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 150000) @(negedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule